// File: doc/BRIEF.md
# Asynchronous SRAM timing controller

The controller turns single-word requests from inside the chip into pin activity for an external asynchronous SRAM or CRAM-style memory. A request carries a write flag, an address, write data and byte enables. The controller drives chip enable, output enable, write enable, the byte-lane selects, the address bus and the data bus through a series of timed phases. It reports the end of the access with a one-cycle done pulse and presents read data at the same time.

Every access begins with an address setup phase followed by a data setup phase. Both lengths are counted in system clock cycles and come from configuration inputs. When extended timing is off, reads and writes share one pair of lengths. When it is on, writes take their lengths from a second, independent pair. A write ends with one extra cycle in which the data stays on the bus after write enable has gone high.

The state machine uses four states. IDLE waits for a request. ADDR is the address setup phase. DATA is the data setup phase. WHOLD is the single data-hold cycle that follows a write. The transitions are:
- IDLE to ADDR when a request is accepted.
- ADDR to DATA when the address count expires.
- DATA to IDLE at the end of a read.
- DATA to WHOLD at the end of a write.
- WHOLD to IDLE always.

Top module: `sram_timing_ctrl`

## Requirements
- R1: After reset and whenever no access is in progress, mem_ce_n, mem_oe_n and mem_we_n are 1, mem_bl_n is 2'b11, mem_dq_oe is 0 and rsp_done is 0.
- R2: An accepted request first spends exactly the effective address-setup count of cycles with mem_ce_n at 0, both strobes at 1 and mem_dq_oe at 0. mem_addr equals req_addr during these cycles and stays stable until mem_ce_n returns to 1.
- R3: A read then holds mem_oe_n at 0 for exactly the effective data-setup count of cycles. mem_dq_oe stays 0 during that time.
- R4: A write then holds mem_we_n at 0 for exactly the effective data-setup count of cycles, with mem_dq_oe at 1 and mem_dq_o equal to req_wdata. One further cycle follows with mem_we_n at 1, mem_ce_n at 0 and the data still driven.
- R5: With cfg_ext_en at 0, both reads and writes use cfg_aset_rd and cfg_dset_rd. With cfg_ext_en at 1, reads use cfg_aset_rd and cfg_dset_rd, and writes use cfg_aset_wr and cfg_dset_wr.
- R6: A programmed setup value of 0 is treated as 1 cycle. Address setup is 4 bits wide and data setup is 8 bits wide.
- R7: rsp_done is high for exactly one cycle. It is due in the cycle after the last cycle of the access: cycle A+D+1 for a read and cycle A+D+2 for a write, counting the first cycle after the accepting edge as cycle 1. On a read, rsp_rdata carries the mem_dq_i value sampled in the last data-setup cycle.
- R8: While mem_ce_n is 0, mem_bl_n is the inverse of req_be on a write (bit i low selects byte i, where byte 0 is data bits 7:0) and 2'b00 on a read.
- R9: A request is accepted only in IDLE. While an access is in progress, req_valid and the other request inputs have no effect on any pin or on the access length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_ext_en | input | 1 | Selects separate write timing when 1 |
| cfg_aset_rd | input | 4 | Address setup cycles, primary set |
| cfg_dset_rd | input | 8 | Data setup cycles, primary set |
| cfg_aset_wr | input | 4 | Address setup cycles, write set |
| cfg_dset_wr | input | 8 | Data setup cycles, write set |
| req_valid | input | 1 | Request strobe, taken in IDLE |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | 26 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables, active high |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Captured read data |
| mem_addr | output | 26 | Memory address pins |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_bl_n | output | 2 | Byte-lane selects, active low |
| mem_dq_o | output | 16 | Data driven toward memory |
| mem_dq_oe | output | 1 | Data bus drive enable |
| mem_dq_i | input | 16 | Data returned by memory |

## Verification
The pins are decoded from registered state, so every phase is visible in the same cycle the state register enters it. The bench samples at the falling edge after the accepting rising edge and numbers that sample cycle 1. From there it counts address cycles, strobe cycles and the hold cycle, and expects rsp_done at cycle A+D+1 for a read or A+D+2 for a write. Those expectations are computed from the configuration with the zero-to-one rule applied. Read data is checked at the done cycle against a shadow copy that the bench builds from the byte enables of earlier writes. In the cycle after done, the bench also checks that the pins have gone idle.

// File: rtl/sramc_pkg.sv
package sramc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ADDR  = 2'd1,
        ST_DATA  = 2'd2,
        ST_WHOLD = 2'd3
    } sramc_state_e;
endpackage

// File: rtl/sramc_tsel.sv
module sramc_tsel #(
    parameter int ASET_W = 4,
    parameter int DSET_W = 8
) (
    input  logic              ext_en,
    input  logic              is_write,
    input  logic [ASET_W-1:0] aset_rd,
    input  logic [DSET_W-1:0] dset_rd,
    input  logic [ASET_W-1:0] aset_wr,
    input  logic [DSET_W-1:0] dset_wr,
    output logic [ASET_W-1:0] aset_eff,
    output logic [DSET_W-1:0] dset_eff
);
    logic use_wr;
    logic [ASET_W-1:0] aset_sel;
    logic [DSET_W-1:0] dset_sel;

    always_comb begin
        use_wr   = ext_en && is_write;
        aset_sel = use_wr ? aset_wr : aset_rd;
        dset_sel = use_wr ? dset_wr : dset_rd;
        aset_eff = (aset_sel == '0) ? ASET_W'(1) : aset_sel;
        dset_eff = (dset_sel == '0) ? DSET_W'(1) : dset_sel;
    end
endmodule

// File: rtl/sramc_cnt.sv
module sramc_cnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         last
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val - W'(1);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - W'(1);
        end
    end

    assign last = (cnt_q == '0);
endmodule

// File: rtl/sram_timing_ctrl.sv
module sram_timing_ctrl
    import sramc_pkg::*;
#(
    parameter int ADDR_W = 26,
    parameter int DATA_W = 16,
    parameter int ASET_W = 4,
    parameter int DSET_W = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_ext_en,
    input  logic [ASET_W-1:0]      cfg_aset_rd,
    input  logic [DSET_W-1:0]      cfg_dset_rd,
    input  logic [ASET_W-1:0]      cfg_aset_wr,
    input  logic [DSET_W-1:0]      cfg_dset_wr,
    input  logic                   req_valid,
    input  logic                   req_write,
    input  logic [ADDR_W-1:0]      req_addr,
    input  logic [DATA_W-1:0]      req_wdata,
    input  logic [DATA_W/8-1:0]    req_be,
    output logic                   rsp_done,
    output logic [DATA_W-1:0]      rsp_rdata,
    output logic [ADDR_W-1:0]      mem_addr,
    output logic                   mem_ce_n,
    output logic                   mem_oe_n,
    output logic                   mem_we_n,
    output logic [DATA_W/8-1:0]    mem_bl_n,
    output logic [DATA_W-1:0]      mem_dq_o,
    output logic                   mem_dq_oe,
    input  logic [DATA_W-1:0]      mem_dq_i
);
    localparam int LANES = DATA_W / 8;

    sramc_state_e state_q, state_d;

    logic [ASET_W-1:0] aset_eff;
    logic [DSET_W-1:0] dset_eff;
    logic [DSET_W-1:0] dset_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [LANES-1:0]  lanes_q;
    logic              wr_q;
    logic [DATA_W-1:0] rdata_q;
    logic              done_q;

    logic              cnt_load;
    logic [DSET_W-1:0] cnt_val;
    logic              cnt_last;
    logic              accept;
    logic              rd_end;

    sramc_tsel #(.ASET_W(ASET_W), .DSET_W(DSET_W)) tsel_i (
        .ext_en   (cfg_ext_en),
        .is_write (req_write),
        .aset_rd  (cfg_aset_rd),
        .dset_rd  (cfg_dset_rd),
        .aset_wr  (cfg_aset_wr),
        .dset_wr  (cfg_dset_wr),
        .aset_eff (aset_eff),
        .dset_eff (dset_eff)
    );

    sramc_cnt #(.W(DSET_W)) cnt_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (cnt_val),
        .last     (cnt_last)
    );

    // Next state and phase counter control
    always_comb begin
        state_d  = state_q;
        cnt_load = 1'b0;
        cnt_val  = '0;
        accept   = 1'b0;
        rd_end   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    accept   = 1'b1;
                    cnt_load = 1'b1;
                    cnt_val  = DSET_W'(aset_eff);
                    state_d  = ST_ADDR;
                end
            end
            ST_ADDR: begin
                if (cnt_last) begin
                    cnt_load = 1'b1;
                    cnt_val  = dset_q;
                    state_d  = ST_DATA;
                end
            end
            ST_DATA: begin
                if (cnt_last) begin
                    rd_end  = !wr_q;
                    state_d = wr_q ? ST_WHOLD : ST_IDLE;
                end
            end
            ST_WHOLD: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Request capture, read capture and completion pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            lanes_q <= '0;
            wr_q    <= 1'b0;
            dset_q  <= DSET_W'(1);
            rdata_q <= '0;
            done_q  <= 1'b0;
        end else begin
            if (accept) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
                lanes_q <= req_write ? req_be : {LANES{1'b1}};
                wr_q    <= req_write;
                dset_q  <= dset_eff;
            end
            if (rd_end) begin
                rdata_q <= mem_dq_i;
            end
            done_q <= rd_end || (state_q == ST_WHOLD);
        end
    end

    // Pin decode from registered state
    always_comb begin
        mem_ce_n  = 1'b1;
        mem_oe_n  = 1'b1;
        mem_we_n  = 1'b1;
        mem_dq_oe = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_ADDR:  mem_ce_n = 1'b0;
            ST_DATA: begin
                mem_ce_n  = 1'b0;
                mem_oe_n  = wr_q;
                mem_we_n  = !wr_q;
                mem_dq_oe = wr_q;
            end
            ST_WHOLD: begin
                mem_ce_n  = 1'b0;
                mem_dq_oe = 1'b1;
            end
        endcase
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign mem_bl_n[g] = !(lanes_q[g] && !mem_ce_n);
    end

    assign mem_addr  = addr_q;
    assign mem_dq_o  = wdata_q;
    assign rsp_rdata = rdata_q;
    assign rsp_done  = done_q;
endmodule

// File: rtl/sramc_chk.sv
module sramc_chk #(
    parameter int ADDR_W = 26,
    parameter int LANES  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_ce_n,
    input logic              mem_oe_n,
    input logic              mem_we_n,
    input logic              mem_dq_oe,
    input logic [LANES-1:0]  mem_bl_n,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              rsp_done
);
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        mem_ce_n |-> (mem_oe_n && mem_we_n && !mem_dq_oe && (mem_bl_n == {LANES{1'b1}})));

    a_r3_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (!mem_dq_oe && mem_we_n));

    a_r4_data_held_at_we_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (mem_dq_oe && !mem_ce_n));

    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    a_r2_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && !$past(mem_ce_n)) |-> $stable(mem_addr));

    a_r8_read_lanes: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (mem_bl_n == {LANES{1'b0}}));
endmodule

bind sram_timing_ctrl sramc_chk #(.ADDR_W(ADDR_W), .LANES(DATA_W / 8)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_ce_n  (mem_ce_n),
    .mem_oe_n  (mem_oe_n),
    .mem_we_n  (mem_we_n),
    .mem_dq_oe (mem_dq_oe),
    .mem_bl_n  (mem_bl_n),
    .mem_addr  (mem_addr),
    .rsp_done  (rsp_done)
);

// File: tb/sram_timing_ctrl_tb_top.sv
module sram_timing_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_ext_en = 1'b0;
    logic [3:0]  cfg_aset_rd = 4'd1;
    logic [7:0]  cfg_dset_rd = 8'd1;
    logic [3:0]  cfg_aset_wr = 4'd1;
    logic [7:0]  cfg_dset_wr = 8'd1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [25:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_be = '0;
    logic        rsp_done;
    logic [15:0] rsp_rdata;
    logic [25:0] mem_addr;
    logic        mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [1:0]  mem_bl_n;
    logic [15:0] mem_dq_o;
    logic [15:0] mem_dq_i;

    int n_checks = 0;
    int n_err = 0;

    always #5 clk = !clk;

    sram_timing_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_ext_en(cfg_ext_en),
        .cfg_aset_rd(cfg_aset_rd), .cfg_dset_rd(cfg_dset_rd),
        .cfg_aset_wr(cfg_aset_wr), .cfg_dset_wr(cfg_dset_wr),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_be(req_be), .rsp_done(rsp_done),
        .rsp_rdata(rsp_rdata), .mem_addr(mem_addr), .mem_ce_n(mem_ce_n),
        .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_bl_n(mem_bl_n),
        .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
    );

    // Memory model driven only by the pins
    logic [15:0] mem_model [256];
    logic [15:0] shadow    [256];
    initial begin
        for (int i = 0; i < 256; i++) begin
            mem_model[i] = '0;
            shadow[i]    = '0;
        end
    end
    always @(posedge clk) begin
        if (!mem_ce_n && !mem_we_n && mem_dq_oe) begin
            if (!mem_bl_n[0]) mem_model[mem_addr[7:0]][7:0]  <= mem_dq_o[7:0];
            if (!mem_bl_n[1]) mem_model[mem_addr[7:0]][15:8] <= mem_dq_o[15:8];
        end
    end
    assign mem_dq_i = (!mem_ce_n && !mem_oe_n) ? mem_model[mem_addr[7:0]] : 16'hDEAD;

    typedef struct packed {
        logic        wr;
        logic        ext;
        logic [3:0]  ar;
        logic [7:0]  dr;
        logic [3:0]  aw;
        logic [7:0]  dw;
        logic [7:0]  addr;
        logic [15:0] data;
        logic [1:0]  be;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VECS [NVEC] = '{
        '{1'b1, 1'b0, 4'd2,  8'd3,   4'd9, 8'd9, 8'h10, 16'hA5C3, 2'b11},
        '{1'b0, 1'b0, 4'd2,  8'd3,   4'd9, 8'd9, 8'h10, 16'h0000, 2'b00},
        '{1'b1, 1'b1, 4'd1,  8'd1,   4'd5, 8'd7, 8'h20, 16'h1234, 2'b01},
        '{1'b0, 1'b1, 4'd1,  8'd1,   4'd5, 8'd7, 8'h20, 16'h0000, 2'b00},
        '{1'b1, 1'b1, 4'd0,  8'd0,   4'd0, 8'd0, 8'h30, 16'hBEEF, 2'b10},
        '{1'b0, 1'b1, 4'd0,  8'd0,   4'd0, 8'd0, 8'h30, 16'h0000, 2'b00},
        '{1'b0, 1'b0, 4'd15, 8'd255, 4'd1, 8'd1, 8'h10, 16'h0000, 2'b00},
        '{1'b1, 1'b0, 4'd3,  8'd0,   4'd1, 8'd1, 8'h40, 16'hFFFF, 2'b11}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Runs one access; when pester is set, conflicting requests are held during the access
    task automatic run_txn(input vec_t v, input bit pester);
        int a_exp, d_exp, lat_exp, cyc;
        int n_addr, n_oe, n_we, n_hold;
        bit bad_addr, bad_bl, bad_dq, bad_cont;
        logic [15:0] exp_rd;
        if (v.wr && v.ext) begin
            a_exp = (v.aw == 0) ? 1 : int'(v.aw);
            d_exp = (v.dw == 0) ? 1 : int'(v.dw);
        end else begin
            a_exp = (v.ar == 0) ? 1 : int'(v.ar);
            d_exp = (v.dr == 0) ? 1 : int'(v.dr);
        end
        lat_exp = a_exp + d_exp + (v.wr ? 2 : 1);
        n_addr = 0; n_oe = 0; n_we = 0; n_hold = 0;
        bad_addr = 0; bad_bl = 0; bad_dq = 0; bad_cont = 0;
        @(negedge clk);
        cfg_ext_en  = v.ext;
        cfg_aset_rd = v.ar; cfg_dset_rd = v.dr;
        cfg_aset_wr = v.aw; cfg_dset_wr = v.dw;
        req_valid = 1'b1; req_write = v.wr;
        req_addr = {18'd0, v.addr}; req_wdata = v.data; req_be = v.be;
        cyc = 0;
        while (cyc < 2000) begin
            @(negedge clk);
            cyc++;
            if (pester) begin
                req_valid = (cyc < lat_exp - 1);
                req_write = !v.wr; req_addr = 26'h00000EE;
                req_wdata = 16'h5A5A; req_be = ~v.be;
            end else begin
                req_valid = 1'b0;
            end
            if (rsp_done) break;
            if (!mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe) begin
                n_addr++;
                if (mem_addr !== {18'd0, v.addr}) bad_addr = 1;
            end
            if (!mem_oe_n) begin
                n_oe++;
                if (mem_dq_oe) bad_cont = 1;
            end
            if (!mem_we_n) begin
                n_we++;
                if (!mem_dq_oe || mem_dq_o !== v.data) bad_dq = 1;
            end
            if (!mem_ce_n && mem_we_n && mem_oe_n && mem_dq_oe) n_hold++;
            if (!mem_ce_n && mem_bl_n !== (v.wr ? ~v.be : 2'b00)) bad_bl = 1;
        end
        check("R7 done latency", cyc, lat_exp);
        check("R2 address phase cycles", n_addr, a_exp);
        check("R2 address value", {31'd0, bad_addr}, 0);
        check("R8 byte lanes", {31'd0, bad_bl}, 0);
        if (v.wr) begin
            check("R4 write strobe cycles", n_we, d_exp);
            check("R4 write hold cycle", n_hold, 1);
            check("R4 write data on bus", {31'd0, bad_dq}, 0);
            check("R9 no read strobe on write", n_oe, 0);
            if (v.be[0]) shadow[v.addr][7:0]  = v.data[7:0];
            if (v.be[1]) shadow[v.addr][15:8] = v.data[15:8];
        end else begin
            exp_rd = shadow[v.addr];
            check("R3 read strobe cycles", n_oe, d_exp);
            check("R3 no drive during read", {31'd0, bad_cont}, 0);
            check("R9 no write strobe on read", n_we, 0);
            check("R7 read data", rsp_rdata, exp_rd);
        end
        req_valid = 1'b0;
        @(negedge clk);
        check("R7 done one cycle", rsp_done, 0);
        check("R1 idle after access", {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe, mem_bl_n}, 6'b111011);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset pins", {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe, mem_bl_n, rsp_done}, 7'b1110110);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle after reset", {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe, mem_bl_n, rsp_done}, 7'b1110110);

        // Vector table: R5 timing sets, R6 zero clamp, R8 lanes
        for (int i = 0; i < NVEC; i++) begin
            run_txn(VECS[i], 1'b0);
        end

        // R9: conflicting requests held during a read and during a write
        run_txn('{1'b0, 1'b1, 4'd2, 8'd2, 4'd3, 8'd4, 8'h40, 16'h0000, 2'b00}, 1'b1);
        run_txn('{1'b1, 1'b1, 4'd2, 8'd2, 4'd3, 8'd4, 8'h50, 16'h0F0F, 2'b11}, 1'b1);
        run_txn('{1'b0, 1'b0, 4'd1, 8'd1, 4'd1, 8'd1, 8'h50, 16'h0000, 2'b00}, 1'b0);
        run_txn('{1'b0, 1'b0, 4'd1, 8'd1, 4'd1, 8'd1, 8'hEE, 16'h0000, 2'b00}, 1'b0);

        $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    end
endmodule